// File: doc/BRIEF.md
# Completion Ring Writer

This block is the hardware producer side of a completion ring that lives in host memory and serves card-to-host streaming. Each time a packet finishes, upstream logic hands the block the number of receive descriptors that packet consumed, the packet length and 32 bits of user metadata. The block turns that into one 16-byte completion entry and issues a write request for the next free ring slot. The entry carries a color bit that flips each time the ring wraps, so software can tell fresh entries from stale ones without reading any other location.

After every entry, the block issues a second write to the final slot of the ring. That slot is reserved as a status record and holds the new producer index and color. Software may therefore poll either the color bit or the status record. Software hands back its consumer index through a single register write. The block refuses new packets while the ring is full, and it flags consumer indices that fall outside the ring. The ring base is taken as 4 KB aligned, and the ring size is one of 16 power-of-two sizes.

Top module: `cmpt_ring_writer`

## Requirements
- R1: While `cfg_enable` is low or reset is asserted, `in_ready`, `wr_valid` and `err_cidx` are 0. After `cfg_enable` rises, the write index starts at 0 and the color starts at 1.
- R2: Entry data layout: bit 0 holds the color, bits [15:8] hold the descriptor count, bits [31:16] hold the packet length, bits [63:32] hold the user metadata, and every other bit is 0.
- R3: An entry for slot i is written to address (cfg_base with bits [11:0] cleared) + 16*i. The low 12 bits of `cfg_base` have no effect.
- R4: Each entry write is followed by exactly one status write to slot size-1. Its data holds the new producer index in bits [16+IDX_W-1:16] and, in bit 0, the color that the entry at that index will carry. All other bits are 0.
- R5: After the entry in slot size-2 is written, the producer index returns to 0 and the color toggles. Completion entries are only ever written to slots 0..size-2.
- R6: `in_ready` is 0 whenever (write index + 1) mod (size-1) equals the stored consumer index.
- R7: A consumer index write with a value above size-2 leaves the stored consumer index unchanged. It also sets `err_cidx`, which stays set until `cfg_enable` falls.
- R8: The ring size is 4 << `cfg_size_sel` slots, which gives 16 sizes from 4 to 131072.
- R9: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R10: At most one packet is in flight. `in_ready` is 0 while a write is pending, and the entry write is presented in the cycle after the packet is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Queue enable; low clears indices, color and error |
| cfg_base | input | ADDR_W | Ring base address (4 KB aligned, low bits ignored) |
| cfg_size_sel | input | 4 | Ring size select, size = 4 << sel |
| in_valid | input | 1 | Completed packet offered |
| in_ready | output | 1 | Packet accepted when high with in_valid |
| in_desc_cnt | input | CNT_W | Descriptors consumed by the packet |
| in_pkt_len | input | LEN_W | Packet length in bytes |
| in_user | input | 32 | User metadata |
| cidx_wr | input | 1 | Software consumer index write strobe |
| cidx_val | input | IDX_W | Software consumer index value |
| wr_valid | output | 1 | Host write request valid |
| wr_ready | input | 1 | Host write request taken |
| wr_addr | output | ADDR_W | Host write byte address |
| wr_data | output | 128 | Host write data (16 bytes) |
| err_cidx | output | 1 | Sticky out-of-range consumer index flag |

## Verification
A consumer index update and a packet offer can land in the same cycle while the ring is full. In that case the ready decision uses the stored consumer index from before the update. The bench sets up a full ring and then drives `cidx_wr` and `in_valid` together. It checks that no write starts at that edge, that `in_ready` rises in the following cycle, and that the packet is then taken into the slot freed by the update. A second overlap is a write stalled by `wr_ready` while a new packet waits. There the bench checks that the request holds still and that the packet is not taken.

// File: rtl/cmpt_pkg.sv
// Shared types and field positions for the completion ring writer.
// Assumes a 128-bit host write and a 4 KB ring base granule.
package cmpt_pkg;
    localparam int ENTRY_BYTES_LOG2 = 4;
    localparam int BASE_ALIGN_BITS  = 12;
    localparam int ENT_CNT_LSB      = 8;
    localparam int ENT_LEN_LSB      = 16;
    localparam int ENT_USER_LSB     = 32;
    localparam int STS_IDX_LSB      = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ENTRY = 2'd1,
        SEQ_STAT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/cmpt_ring_ptr.sv
// Producer index, color and consumer index bookkeeping for one ring.
// Assumes cfg_size_sel is held stable while cfg_enable is high.
module cmpt_ring_ptr #(
    parameter int MIN_LOG2 = 2,
    parameter int IDX_W    = MIN_LOG2 + 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [3:0]       cfg_size_sel,
    input  logic             advance,
    input  logic             cidx_wr,
    input  logic [IDX_W-1:0] cidx_val,
    output logic [IDX_W-1:0] cur_idx,
    output logic             cur_color,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             nxt_color,
    output logic [IDX_W-1:0] last_idx,
    output logic             full,
    output logic             err_cidx
);
    logic [IDX_W:0]   slots;
    logic [IDX_W-1:0] max_idx;
    logic [IDX_W-1:0] cidx_q;
    logic             wrap;

    // Derive slot count and index limits from the size select.
    always_comb begin
        slots    = (IDX_W+1)'(1) << (MIN_LOG2 + int'(cfg_size_sel));
        last_idx = IDX_W'(slots - (IDX_W+1)'(1));
        max_idx  = IDX_W'(slots - (IDX_W+1)'(2));
        wrap     = (cur_idx == max_idx);
        nxt_idx  = wrap ? '0 : cur_idx + IDX_W'(1);
        nxt_color = wrap ? ~cur_color : cur_color;
        full     = (nxt_idx == cidx_q);
    end

    // Advance producer index and color on each accepted packet.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_enable) begin
            cur_idx   <= '0;
            cur_color <= 1'b1;
        end else if (advance) begin
            cur_idx   <= nxt_idx;
            cur_color <= nxt_color;
        end
    end

    // Capture software consumer index, flag out-of-range values.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_enable) begin
            cidx_q   <= '0;
            err_cidx <= 1'b0;
        end else if (cidx_wr) begin
            if (cidx_val <= max_idx) cidx_q <= cidx_val;
            else                     err_cidx <= 1'b1;
        end
    end
endmodule

// File: rtl/cmpt_fmt.sv
// Builds entry and status write address/data from captured packet fields.
// Purely combinational; assumes count and length fit their fields.
module cmpt_fmt
    import cmpt_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 17,
    parameter int CNT_W  = 8,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              sel_status,
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic              ent_color,
    input  logic [CNT_W-1:0]  ent_cnt,
    input  logic [LEN_W-1:0]  ent_len,
    input  logic [31:0]       ent_user,
    input  logic [IDX_W-1:0]  sts_idx,
    input  logic              sts_color,
    input  logic [IDX_W-1:0]  last_idx,
    output logic [ADDR_W-1:0] addr,
    output logic [127:0]      data
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W)'(1) << BASE_ALIGN_BITS) + (ADDR_W)'(1);

    logic [ADDR_W-1:0] base_al;
    logic [IDX_W-1:0]  slot;

    // Choose slot, align base and pack the selected record.
    always_comb begin
        base_al = cfg_base & ALIGN_MASK;
        slot    = sel_status ? last_idx : ent_idx;
        addr    = base_al + (ADDR_W'(slot) << ENTRY_BYTES_LOG2);
        data    = '0;
        if (sel_status) begin
            data[0] = sts_color;
            data[STS_IDX_LSB +: IDX_W] = sts_idx;
        end else begin
            data[0] = ent_color;
            data[ENT_CNT_LSB +: CNT_W]  = ent_cnt;
            data[ENT_LEN_LSB +: LEN_W]  = ent_len;
            data[ENT_USER_LSB +: 32]    = ent_user;
        end
    end
endmodule

// File: rtl/cmpt_wr_seq.sv
// Sequences one entry write then one status write per accepted packet.
// Assumes the host side obeys valid/ready; disable aborts pending writes.
module cmpt_wr_seq
    import cmpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_enable,
    input  logic full,
    input  logic in_valid,
    input  logic wr_ready,
    output logic in_ready,
    output logic accept,
    output logic wr_valid,
    output logic sel_status
);
    seq_state_t state;

    // Handshake decode from current state.
    always_comb begin
        in_ready   = cfg_enable && (state == SEQ_IDLE) && !full;
        accept     = in_valid && in_ready;
        wr_valid   = (state != SEQ_IDLE);
        sel_status = (state == SEQ_STAT);
    end

    // Step through entry and status writes.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_enable) begin
            state <= SEQ_IDLE;
        end else begin
            unique case (state)
                SEQ_IDLE:  if (accept)   state <= SEQ_ENTRY;
                SEQ_ENTRY: if (wr_ready) state <= SEQ_STAT;
                SEQ_STAT:  if (wr_ready) state <= SEQ_IDLE;
                default:                 state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmpt_ring_writer.sv
// Completion ring producer: one entry plus one status update per packet.
// Assumes configuration is stable while enabled; no host bus logic here.
module cmpt_ring_writer #(
    parameter int ADDR_W   = 64,
    parameter int MIN_LOG2 = 2,
    parameter int IDX_W    = MIN_LOG2 + 15,
    parameter int CNT_W    = 8,
    parameter int LEN_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [3:0]        cfg_size_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CNT_W-1:0]  in_desc_cnt,
    input  logic [LEN_W-1:0]  in_pkt_len,
    input  logic [31:0]       in_user,
    input  logic              cidx_wr,
    input  logic [IDX_W-1:0]  cidx_val,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [127:0]      wr_data,
    output logic              err_cidx
);
    logic [IDX_W-1:0] cur_idx, nxt_idx, last_idx;
    logic             cur_color, nxt_color, full, accept, sel_status;
    logic [IDX_W-1:0] e_idx, s_idx;
    logic             e_color, s_color;
    logic [CNT_W-1:0] e_cnt;
    logic [LEN_W-1:0] e_len;
    logic [31:0]      e_user;

    cmpt_ring_ptr #(.MIN_LOG2(MIN_LOG2), .IDX_W(IDX_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_size_sel(cfg_size_sel), .advance(accept),
        .cidx_wr(cidx_wr), .cidx_val(cidx_val),
        .cur_idx(cur_idx), .cur_color(cur_color),
        .nxt_idx(nxt_idx), .nxt_color(nxt_color),
        .last_idx(last_idx), .full(full), .err_cidx(err_cidx)
    );

    cmpt_wr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .full(full),
        .in_valid(in_valid), .wr_ready(wr_ready), .in_ready(in_ready),
        .accept(accept), .wr_valid(wr_valid), .sel_status(sel_status)
    );

    // Capture packet fields and index snapshot at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_idx <= '0; e_color <= 1'b0; s_idx <= '0; s_color <= 1'b0;
            e_cnt <= '0; e_len <= '0; e_user <= '0;
        end else if (accept) begin
            e_idx   <= cur_idx;
            e_color <= cur_color;
            s_idx   <= nxt_idx;
            s_color <= nxt_color;
            e_cnt   <= in_desc_cnt;
            e_len   <= in_pkt_len;
            e_user  <= in_user;
        end
    end

    cmpt_fmt #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_fmt (
        .cfg_base(cfg_base), .sel_status(sel_status),
        .ent_idx(e_idx), .ent_color(e_color), .ent_cnt(e_cnt),
        .ent_len(e_len), .ent_user(e_user),
        .sts_idx(s_idx), .sts_color(s_color), .last_idx(last_idx),
        .addr(wr_addr), .data(wr_data)
    );
endmodule

// File: rtl/cmpt_ring_writer_chk.sv
// Protocol and flag checks for cmpt_ring_writer, attached by bind.
module cmpt_ring_writer_chk #(
    parameter int ADDR_W   = 64,
    parameter int MIN_LOG2 = 2,
    parameter int IDX_W    = MIN_LOG2 + 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic [3:0]        cfg_size_sel,
    input logic              in_valid,
    input logic              in_ready,
    input logic              cidx_wr,
    input logic [IDX_W-1:0]  cidx_val,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [127:0]      wr_data,
    input logic              err_cidx
);
    logic [IDX_W:0] chk_max;
    always_comb chk_max = ((IDX_W+1)'(1) << (MIN_LOG2 + int'(cfg_size_sel))) - (IDX_W+1)'(2);

    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && wr_valid && !wr_ready) |=> (!cfg_enable || (wr_valid && $stable(wr_addr) && $stable(wr_data))));

    // R10
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !in_ready);

    // R10
    entry_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cfg_enable) |=> (!cfg_enable || wr_valid));

    // R7
    bad_cidx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cidx_wr && ({1'b0, cidx_val} > chk_max)) |=> (!cfg_enable || err_cidx));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && err_cidx) |=> (!cfg_enable || err_cidx));

    // R3
    addr_granule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[3:0] == 4'd0));

    // R1
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!cfg_enable -> (!in_ready && !err_cidx)));
endmodule

bind cmpt_ring_writer cmpt_ring_writer_chk #(
    .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_size_sel(cfg_size_sel),
    .in_valid(in_valid), .in_ready(in_ready), .cidx_wr(cidx_wr), .cidx_val(cidx_val),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_cidx(err_cidx)
);

// File: tb/tb_cmpt_ring_writer.sv
module tb_cmpt_ring_writer;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 64;
    localparam int IDX_W  = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_enable = 1'b0;
    logic [ADDR_W-1:0] cfg_base = 64'h0000_0012_3456_7ABC;
    logic [3:0]        cfg_size_sel = 4'd0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [7:0]        in_desc_cnt = '0;
    logic [15:0]       in_pkt_len = '0;
    logic [31:0]       in_user = '0;
    logic              cidx_wr = 1'b0;
    logic [IDX_W-1:0]  cidx_val = '0;
    logic              wr_valid;
    logic              wr_ready = 1'b1;
    logic [ADDR_W-1:0] wr_addr;
    logic [127:0]      wr_data;
    logic              err_cidx;

    int n_chk = 0;
    int n_bad = 0;

    logic [ADDR_W-1:0] base_al;
    int exp_idx;
    logic exp_col;
    int slots;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmpt_ring_writer dut (.*);

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_cidx(input int v);
        @(negedge clk);
        cidx_wr = 1'b1; cidx_val = IDX_W'(v);
        @(negedge clk);
        cidx_wr = 1'b0;
    endtask

    // Offer one packet, wait for acceptance, then check entry and status writes.
    task automatic push_and_check(input logic [7:0] cnt, input logic [15:0] len, input logic [31:0] usr);
        logic [127:0] exp_d;
        @(negedge clk);
        in_valid = 1'b1; in_desc_cnt = cnt; in_pkt_len = len; in_user = usr;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        while (!wr_valid) @(negedge clk);
        exp_d = '0; exp_d[0] = exp_col; exp_d[15:8] = cnt; exp_d[31:16] = len; exp_d[63:32] = usr;
        // R3
        check(wr_addr == base_al + ADDR_W'(exp_idx * 16), "R3 entry address", wr_addr, base_al + ADDR_W'(exp_idx * 16));
        // R2
        check(wr_data == exp_d, "R2 entry data", wr_data, exp_d);
        if (exp_idx == slots - 2) begin exp_idx = 0; exp_col = ~exp_col; end
        else exp_idx++;
        @(negedge clk);
        exp_d = '0; exp_d[0] = exp_col; exp_d[16 +: IDX_W] = IDX_W'(exp_idx);
        // R4 R8
        check(wr_valid && wr_addr == base_al + ADDR_W'((slots - 1) * 16), "R4/R8 status address", wr_addr, base_al + ADDR_W'((slots - 1) * 16));
        // R4 R5
        check(wr_data == exp_d, "R4/R5 status data", wr_data, exp_d);
        @(negedge clk);
    endtask

    task automatic start_queue(input logic [3:0] sel);
        @(negedge clk);
        cfg_enable = 1'b0;
        @(negedge clk);
        cfg_size_sel = sel; cfg_enable = 1'b1;
        slots = 4 << sel; exp_idx = 0; exp_col = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        // R1
        check(!in_ready && !wr_valid && !err_cidx, "R1 idle while disabled", {in_ready, wr_valid, err_cidx}, 0);
    endtask

    task automatic t_basic_and_full;
        start_queue(4'd0);
        push_and_check(8'd3, 16'd1500, 32'hCAFE_0001);
        push_and_check(8'd1, 16'd64, 32'h1234_5678);
        // R6
        check(!in_ready, "R6 full stalls input", in_ready, 0);
    endtask

    task automatic t_bad_cidx_and_wrap;
        set_cidx(3);
        // R7
        check(err_cidx && !in_ready, "R7 out-of-range ignored and flagged", {err_cidx, in_ready}, 2'b10);
        set_cidx(1);
        check(in_ready, "R6 room after cidx update", in_ready, 1);
        push_and_check(8'd2, 16'd9000, 32'hA5A5_5A5A);
        // R5 (wrap done, next entry is slot 0 with color 0)
        check(!in_ready, "R6 full after wrap", in_ready, 0);
        set_cidx(2);
        push_and_check(8'd7, 16'd1, 32'hFFFF_0000);
        check(err_cidx, "R7 flag sticky", err_cidx, 1);
    endtask

    task automatic t_stall;
        logic [ADDR_W-1:0] a0;
        logic [127:0] d0;
        start_queue(4'd1);
        // R7
        check(!err_cidx, "R7 flag cleared by disable", err_cidx, 0);
        wr_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_desc_cnt = 8'd4; in_pkt_len = 16'd256; in_user = 32'h0BAD_F00D;
        @(negedge clk);
        in_valid = 1'b1; in_user = 32'h1111_2222;
        a0 = wr_addr; d0 = wr_data;
        repeat (3) @(negedge clk);
        // R9
        check(wr_valid && wr_addr == a0 && wr_data == d0, "R9 request held under stall", wr_data, d0);
        // R10
        check(!in_ready, "R10 no accept while write pending", in_ready, 0);
        in_valid = 1'b0;
        wr_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!wr_valid, "R10 exactly two writes per packet", wr_valid, 0);
    endtask

    task automatic t_same_cycle;
        start_queue(4'd0);
        push_and_check(8'd1, 16'd10, 32'h1);
        push_and_check(8'd1, 16'd11, 32'h2);
        @(negedge clk);
        cidx_wr = 1'b1; cidx_val = IDX_W'(1);
        in_valid = 1'b1; in_desc_cnt = 8'd5; in_pkt_len = 16'd77; in_user = 32'hBEEF;
        @(negedge clk);
        cidx_wr = 1'b0;
        // R6 R10
        check(in_ready && !wr_valid, "R6 old cidx governs same-cycle offer", {in_ready, wr_valid}, 2'b10);
        @(negedge clk);
        in_valid = 1'b0;
        check(wr_valid && wr_addr == base_al + 64'd32, "R10 entry after same-cycle update", wr_addr, base_al + 64'd32);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_big_size;
        start_queue(4'd15);
        push_and_check(8'd9, 16'd4096, 32'h0F0F_0F0F);
    endtask

    initial begin
        base_al = cfg_base & ~64'hFFF;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_and_full();
        t_bad_cidx_and_wrap();
        t_stall();
        t_same_cycle();
        t_big_size();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule